// File: doc/BRIEF.md
# Asymmetric Edge Delay Filter

This block qualifies one logic input before it reaches the output. A change of input level is copied to the output only after the new level has held for a programmed time. Rising and falling changes each have their own 4-bit delay code. A pulse that ends before its qualifying time is dropped. The block therefore both removes glitches and reshapes the width of pulses.

Time is counted in periods of a one-cycle tick enable, normally one millisecond. Each code selects a fixed number of ticks from a lookup table that runs from zero to 500. At any moment the block has one direction to qualify: rising while the output is low, falling while it is high. It compares the input with the current output. On the first cycle of a disagreement it samples the delay code for that direction. It then counts ticks until the count reaches the sampled value, or until the input agrees with the output again.

Top module: `aedf_edge_filter`

## Requirements
- R1: A synchronous reset (`rst` high) drives `dout` low and clears any count in progress. After reset is released, a held-high input needs the full rising delay before `dout` rises.
- R2: A code maps to a tick count as follows. Code 0 gives 0 ticks, code 15 gives 500 ticks, and any code k from 1 to 14 gives 33*k ticks.
- R3: Suppose the input first differs from `dout` on clock edge E0 and keeps differing. With a nonzero delay of T ticks, `dout` takes the input level on the clock edge that carries the T-th tick asserted after E0, and not earlier.
- R4: If the input goes back low before the rising delay completes, `dout` stays low and the count is discarded. A later rise then counts from zero.
- R5: With rising code 0, `dout` goes high on edge E0, the first edge at which the input is sampled high.
- R6: With falling code 0, `dout` goes low on edge E0, the first edge at which the input is sampled low.
- R7: With a nonzero falling code, `dout` goes low only after the input has stayed low for the full falling delay, counted as in R3.
- R8: If the input goes back high before the falling delay completes, `dout` stays high and the count is discarded.
- R9: Input pulses shorter than the delay of their direction never appear on `dout`. A low input while `dout` is already low has no effect.
- R10: The count advances only on clock edges where `tick_ms` is high. Without ticks, a nonzero delay never completes.
- R11: The delay code is sampled on edge E0. Changing either code while a count runs does not change when that count completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle time-base enable that advances the count |
| din | input | 1 | Logic input to be qualified |
| rise_code | input | 4 | Delay code for low-to-high changes |
| fall_code | input | 4 | Delay code for high-to-low changes |
| dout | output | 1 | Qualified, delayed output |

## Verification
The hardest case to reach is a code change in the middle of a count. The stimulus must first start a count with one code, then rewrite the code several ticks later, and then show that the completion edge matches the old code. The bench does this in both directions. On a fall, it switches the code to zero mid-count, so an implementation that re-reads the code would drop the output at once. Aborted counts and tick starvation are reached the same way: the bench holds the input for a known number of cycles under a controlled tick pattern and then probes the exact completion edge.

// File: rtl/aedf_pkg.sv
package aedf_pkg;

    typedef enum logic {
        QUAL_IDLE  = 1'b0,
        QUAL_ARMED = 1'b1
    } qual_e;

    // Tick count for a delay code: zero for the lowest code, max for the
    // highest, an even step of max/(ncodes-1) for the codes between.
    function automatic int unsigned code_to_ticks(input int unsigned code,
                                                  input int unsigned max_ticks,
                                                  input int unsigned ncodes);
        int unsigned step;
        step = max_ticks / (ncodes - 1);
        if (code >= ncodes - 1)
            return max_ticks;
        return code * step;
    endfunction

endpackage

// File: rtl/aedf_delay_lut.sv
module aedf_delay_lut #(
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned MAX_TICKS = 500,
    parameter int unsigned CNT_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  ticks_o
);
    localparam int unsigned NCODES = 1 << CODE_W;

    logic [CNT_W-1:0] tbl [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_entry
        assign tbl[g] = CNT_W'(aedf_pkg::code_to_ticks(g, MAX_TICKS, NCODES));
    end

    assign ticks_o = tbl[code_i];

endmodule

// File: rtl/aedf_tick_timer.sv
module aedf_tick_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             armed_o,
    output logic             done_o
);
    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] target;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear_i) begin
            t_d.armed = 1'b0;
            t_d.count = '0;
        end else if (load_i) begin
            t_d.armed  = 1'b1;
            t_d.count  = '0;
            t_d.target = target_i;
        end else if (t_q.armed && tick_i) begin
            t_d.count = t_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign armed_o = t_q.armed;
    assign done_o  = t_q.armed && tick_i && ((t_q.count + CNT_W'(1)) == t_q.target);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        t_q.armed |-> (t_q.count < t_q.target));

    // R11
    target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (t_q.armed && !load_i) |=> $stable(t_q.target));

endmodule

// File: rtl/aedf_edge_filter.sv
module aedf_edge_filter #(
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned MAX_TICKS = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ms,
    input  logic              din,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    output logic              dout
);
    import aedf_pkg::*;

    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic  level;
        qual_e st;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [CNT_W-1:0] rise_ticks, fall_ticks, sel_ticks;
    logic             differ, tmr_load, tmr_clear, tmr_armed, tmr_done;

    aedf_delay_lut #(.CODE_W(CODE_W), .MAX_TICKS(MAX_TICKS), .CNT_W(CNT_W)) u_rise_lut (
        .code_i (rise_code),
        .ticks_o(rise_ticks)
    );

    aedf_delay_lut #(.CODE_W(CODE_W), .MAX_TICKS(MAX_TICKS), .CNT_W(CNT_W)) u_fall_lut (
        .code_i (fall_code),
        .ticks_o(fall_ticks)
    );

    aedf_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_ms),
        .load_i  (tmr_load),
        .clear_i (tmr_clear),
        .target_i(sel_ticks),
        .armed_o (tmr_armed),
        .done_o  (tmr_done)
    );

    always_comb begin
        c_d       = c_q;
        tmr_load  = 1'b0;
        tmr_clear = 1'b0;
        differ    = (din != c_q.level);
        sel_ticks = c_q.level ? fall_ticks : rise_ticks;
        unique case (c_q.st)
            QUAL_IDLE: begin
                if (differ) begin
                    if (sel_ticks == '0) begin
                        c_d.level = din;
                    end else begin
                        tmr_load = 1'b1;
                        c_d.st   = QUAL_ARMED;
                    end
                end
            end
            QUAL_ARMED: begin
                if (!differ) begin
                    tmr_clear = 1'b1;
                    c_d.st    = QUAL_IDLE;
                end else if (tmr_done) begin
                    tmr_clear = 1'b1;
                    c_d.level = din;
                    c_d.st    = QUAL_IDLE;
                end
            end
            default: c_d = c_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign dout = c_q.level;

    // R5
    rise_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == QUAL_IDLE && !dout && din && rise_code == '0) |=> dout);

    // R6
    fall_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == QUAL_IDLE && dout && !din && fall_code == '0) |=> !dout);

    // R4
    abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == QUAL_ARMED && din == dout) |=> ($stable(dout) && !tmr_armed));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == QUAL_ARMED && !tick_ms) |=> $stable(dout));

    // R3
    timer_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == QUAL_ARMED) == tmr_armed);

endmodule

// File: tb/aedf_edge_filter_tb.sv
module aedf_edge_filter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b1;
    logic       din = 1'b0;
    logic [3:0] rise_code = '0;
    logic [3:0] fall_code = '0;
    logic       dout;

    int    n_chk = 0;
    int    n_fail = 0;
    int    tick_mode = 0;   // 0 always, 1 never, 2 random, 3 every fourth
    int    cyc_no = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    aedf_edge_filter u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .din(din),
        .rise_code(rise_code), .fall_code(fall_code), .dout(dout)
    );

    // Behavioural reference, from the requirements
    function automatic int ref_ticks(input int code);
        if (code == 15) return 500;
        return 33 * code;
    endfunction

    int m_out = 0, m_busy = 0, m_cnt = 0, m_tgt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_busy = 0; m_cnt = 0;
        end else if (m_busy == 0) begin
            if (int'(din) != m_out) begin
                m_tgt = ref_ticks(m_out == 1 ? int'(fall_code) : int'(rise_code));
                if (m_tgt == 0) m_out = int'(din);
                else begin m_busy = 1; m_cnt = 0; end
            end
        end else begin
            if (int'(din) == m_out) begin
                m_busy = 0; m_cnt = 0;
            end else if (tick_ms) begin
                m_cnt++;
                if (m_cnt == m_tgt) begin m_out = int'(din); m_busy = 0; end
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_no++;
            if (!rst) begin
                n_chk++;
                if (int'(dout) !== m_out) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: dout=%b expected %0d", cur_req, cyc_no, dout, m_out);
                end
            end
            case (tick_mode)
                0: tick_ms = 1'b1;
                1: tick_ms = 1'b0;
                2: tick_ms = 1'($urandom_range(0, 1));
                default: tick_ms = (cyc_no % 4 == 0);
            endcase
        end
    endtask

    task automatic chk(input logic exp, input string req);
        n_chk++;
        if (dout !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%b expected %b", req, dout, exp);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: run hung, dout=%b expected completion", dout);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: reset, then a held input needs the full rising delay
        din = 1'b1; rise_code = 4'd1;
        cyc(3);
        chk(1'b0, "R1");
        rst = 1'b0;
        cyc(33); chk(1'b0, "R1");
        cyc(1);  chk(1'b1, "R3");

        // R6: zero falling code passes the fall on the first edge
        cur_req = "R6";
        fall_code = 4'd0; din = 1'b0;
        cyc(1); chk(1'b0, "R6");

        // R5: zero rising code
        cur_req = "R5";
        rise_code = 4'd0; din = 1'b1;
        cyc(1); chk(1'b1, "R5");

        // R7: falling delay of 66 ticks
        cur_req = "R7";
        fall_code = 4'd2; din = 1'b0;
        cyc(66); chk(1'b1, "R7");
        cyc(1);  chk(1'b0, "R7");

        // R4: aborted rise, then a fresh full count
        cur_req = "R4";
        rise_code = 4'd1; din = 1'b1;
        cyc(20); din = 1'b0;
        cyc(5);  chk(1'b0, "R4");
        din = 1'b1;
        cyc(33); chk(1'b0, "R4");
        cyc(1);  chk(1'b1, "R4");

        // R8: aborted fall, then a fresh full count
        cur_req = "R8";
        fall_code = 4'd1; din = 1'b0;
        cyc(30); din = 1'b1;
        cyc(50); chk(1'b1, "R8");
        din = 1'b0;
        cyc(33); chk(1'b1, "R8");
        cyc(1);  chk(1'b0, "R8");

        // R10: no ticks, no progress
        cur_req = "R10";
        tick_mode = 1; rise_code = 4'd1; din = 1'b1;
        cyc(200); chk(1'b0, "R10");
        tick_mode = 0;
        cyc(33); chk(1'b0, "R10");
        cyc(1);  chk(1'b1, "R10");
        tick_mode = 3; fall_code = 4'd1; din = 1'b0;
        cyc(200); chk(1'b0, "R10");
        tick_mode = 0;

        // R11: code changes mid-count are ignored
        cur_req = "R11";
        rise_code = 4'd1; din = 1'b1;
        cyc(5); rise_code = 4'd15;
        cyc(28); chk(1'b0, "R11");
        cyc(1);  chk(1'b1, "R11");
        fall_code = 4'd1; din = 1'b0;
        cyc(3); fall_code = 4'd0;
        cyc(2);  chk(1'b1, "R11");
        cyc(28); chk(1'b1, "R11");
        cyc(1);  chk(1'b0, "R11");

        // R2: end and middle codes of the table
        cur_req = "R2";
        rise_code = 4'd15; din = 1'b1;
        cyc(500); chk(1'b0, "R2");
        cyc(1);   chk(1'b1, "R2");
        fall_code = 4'd7; din = 1'b0;
        cyc(231); chk(1'b1, "R2");
        cyc(1);   chk(1'b0, "R2");

        // R9: short pulses in both directions are swallowed
        cur_req = "R9";
        rise_code = 4'd3;
        for (int p = 1; p < 99; p += 7) begin
            din = 1'b1; cyc(p);
            din = 1'b0; cyc(3);
            chk(1'b0, "R9");
        end
        rise_code = 4'd0; din = 1'b1; cyc(2);
        fall_code = 4'd3;
        for (int p = 1; p < 99; p += 9) begin
            din = 1'b0; cyc(p);
            din = 1'b1; cyc(3);
            chk(1'b1, "R9");
        end

        // Mixed random traffic against the reference: R3 and R7 timing
        cur_req = "R3/R7 random";
        tick_mode = 2;
        for (int k = 0; k < 80; k++) begin
            rise_code = 4'($urandom_range(0, 3));
            fall_code = 4'($urandom_range(0, 3));
            if (k % 10 == 9) rise_code = 4'd15;
            din = ~din;
            cyc($urandom_range(1, 150));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule